// File: doc/BRIEF.md
# Framed SPI Slave with Freshness Flag

This block is a serial slave port. It connects an external SPI master to an internal byte data path. The serial clock, the chip select and the serial input are brought into a faster system clock through synchronisers. The serial clock edges are then detected in the system domain. Each frame is eleven serial bits long, in this order:

- a direction bit,
- a register-select bit,
- eight data bits,
- a trailing handshake bit that tells the master whether the byte was fresh.

On the internal side the block pops a receive byte source with a FIFO-style pop. It pushes a transmit byte sink with a FIFO-style push. It also returns an 8-bit status word on request. A byte that comes back stale, or a write that the sink refused, is flagged in the trailing bit. The master repeats the frame when it sees that flag.

Top module: `spi_fresh_slave`

## Requirements
- R1: After reset, `sdo` is 0 and neither `rxPop` nor `txPush` is asserted.
- R2: A frame starts only on a rise of `cs` after `cs` has been seen low. Clocks received while `cs` stays high after a completed frame are ignored: no pop, no push, and `sdo` stays 0.
- R3: The first bit sampled on `sdi` picks the direction (1 = read from the slave, 0 = write). The second bit picks the register (0 = data, 1 = status).
- R4: On a read, the eight data bits appear on `sdo` most-significant bit first. Each bit changes after a falling `sclk`. The first data bit is driven after the fall that follows the register-select bit.
- R5: A data read from a non-empty source returns the source head byte and reports 0 in the trailing bit. It pops the source exactly once, with a single-cycle `rxPop` pulse.
- R6: A data read from an empty source repeats the last byte that was popped, reports 1 in the trailing bit, and does not pop.
- R7: A status read returns `statusWord`, reports 0 in the trailing bit, and never pops.
- R8: A write frame captures the eight data bits MSB first and pushes them once on `txData`, reporting 0 in the trailing bit. When `txFull` is high, the byte is dropped and the trailing bit is 1. `rxPop` and `txPush` are never high together.
- R9: If `cs` falls before the trailing bit has been clocked, the frame is abandoned. There is no pop and no push, and the next rise of `cs` starts a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs | input | 1 | Active-high chip select |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| rxData | input | 8 | Head byte of the receive source |
| rxEmpty | input | 1 | Receive source holds no byte |
| rxPop | output | 1 | One-cycle pop of the receive source |
| txData | output | 8 | Byte offered to the transmit sink |
| txPush | output | 1 | One-cycle push into the transmit sink |
| txFull | input | 1 | Transmit sink cannot accept a byte |
| statusWord | input | 8 | Word returned by a status read |

## Verification
A serial pin change reaches the logic after two synchroniser flops and one edge-detect flop. As a result, `sdo` takes its new value three system clocks after a falling `sclk`, and the `rxPop`/`txPush` pulse comes three clocks after the final rising `sclk`. The bench holds each serial clock half-period for four system clocks. It reads `sdo` at the end of the low half, just before raising `sclk`, which is after the update and before the next one. Pop and push effects are counted by the bench's own source and sink models, and they are compared only once the frame has closed and `cs` has been low for several clocks.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FRAME_BITS = DATA_W + 3;
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam int unsigned FIRST_DATA = 2;
  localparam int unsigned LAST_DATA = DATA_W + 1;
  localparam int unsigned FLAG_POS = DATA_W + 2;

  typedef enum logic [1:0] {
    ST_WAITLOW,
    ST_ARMED,
    ST_BUSY
  } frameState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadRead;
    logic readStatus;
    logic judgeWrite;
    logic outData;
    logic outFlag;
    logic outClear;
    logic commitPop;
    logic commitPush;
  } spisStrobes_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(STAGES); i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spis_dpath.sv
module spis_dpath
  import spis_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              cs,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxEmpty,
  input  logic              txFull,
  input  logic [DATA_W-1:0] statusWord,
  input  spisStrobes_t      strobes,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              csLevel,
  output logic              sdiLevel,
  output logic              sdo,
  output logic              rxPop,
  output logic              txPush,
  output logic [DATA_W-1:0] txData
);
  logic [2:0] pinSync;
  logic sclkS, sclkPrev;
  logic [DATA_W-1:0] inShift, outShift, readByte, lastByte;
  logic staleFlag, sdoR;

  spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({sclk, cs, sdi}),
    .dout(pinSync)
  );

  assign sclkS = pinSync[2];
  assign csLevel = pinSync[1];
  assign sdiLevel = pinSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;

  // Write path: serial-in shift register, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inShift <= '0;
    else if (strobes.shiftIn) inShift <= {inShift[DATA_W-2:0], sdiLevel};
  end

  // Read source selection and freshness flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readByte  <= '0;
      staleFlag <= 1'b0;
    end else if (strobes.loadRead) begin
      if (strobes.readStatus) begin
        readByte  <= statusWord;
        staleFlag <= 1'b0;
      end else if (!rxEmpty) begin
        readByte  <= rxData;
        staleFlag <= 1'b0;
      end else begin
        readByte  <= lastByte;
        staleFlag <= 1'b1;
      end
    end else if (strobes.judgeWrite) begin
      staleFlag <= txFull;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastByte <= '0;
    else if (rxPop) lastByte <= readByte;
  end

  // Serial-out path, updated on detected falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      sdoR     <= 1'b0;
    end else if (strobes.outClear) begin
      sdoR <= 1'b0;
    end else if (strobes.loadRead) begin
      outShift <= (strobes.readStatus) ? statusWord : ((!rxEmpty) ? rxData : lastByte);
    end else if (strobes.outData) begin
      sdoR     <= outShift[DATA_W-1];
      outShift <= {outShift[DATA_W-2:0], 1'b0};
    end else if (strobes.outFlag) begin
      sdoR <= staleFlag;
    end
  end

  assign sdo    = sdoR;
  assign txData = inShift;
  assign rxPop  = strobes.commitPop & ~staleFlag;
  assign txPush = strobes.commitPush & ~staleFlag;

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> !rxEmpty);
  // R5
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxPop);
  // R8
  push_notfull_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> !txFull);
  // R8
  pop_push_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxPop && txPush));
  // R2
  idle_sdo_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.outClear) |-> !sdo);
endmodule

// File: rtl/spis_ctrl.sv
module spis_ctrl
  import spis_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkRise,
  input  logic         sclkFall,
  input  logic         csLevel,
  input  logic         sdiLevel,
  output spisStrobes_t strobes
);
  frameState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic dirRead, selStatus;
  logic busyAct, inData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_WAITLOW;
      bitCnt    <= '0;
      dirRead   <= 1'b0;
      selStatus <= 1'b0;
    end else begin
      unique case (state)
        ST_WAITLOW: if (!csLevel) state <= ST_ARMED;
        ST_ARMED: if (csLevel) begin
          state  <= ST_BUSY;
          bitCnt <= '0;
        end
        ST_BUSY: begin
          if (!csLevel) begin
            state  <= ST_ARMED;
            bitCnt <= '0;
          end else if (sclkRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(0)) dirRead <= sdiLevel;
            if (bitCnt == CNT_W'(1)) selStatus <= sdiLevel;
            if (bitCnt == CNT_W'(FLAG_POS)) state <= ST_WAITLOW;
          end
        end
        default: state <= ST_WAITLOW;
      endcase
    end
  end

  assign busyAct = (state == ST_BUSY) && csLevel;
  assign inData  = (bitCnt >= CNT_W'(FIRST_DATA)) && (bitCnt <= CNT_W'(LAST_DATA));

  always_comb begin
    strobes            = '0;
    strobes.outClear   = !busyAct;
    strobes.shiftIn    = busyAct && sclkRise && inData;
    strobes.loadRead   = busyAct && sclkRise && (bitCnt == CNT_W'(1)) && dirRead;
    strobes.readStatus = sdiLevel;
    strobes.judgeWrite = busyAct && sclkRise && (bitCnt == CNT_W'(LAST_DATA)) && !dirRead;
    strobes.commitPop  = busyAct && sclkRise && (bitCnt == CNT_W'(FLAG_POS)) && dirRead && !selStatus;
    strobes.commitPush = busyAct && sclkRise && (bitCnt == CNT_W'(FLAG_POS)) && !dirRead;
    strobes.outData    = busyAct && sclkFall && dirRead && inData;
    strobes.outFlag    = busyAct && sclkFall && (bitCnt == CNT_W'(FLAG_POS));
  end

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !csLevel) |=> (state == ST_ARMED));
  // R2
  need_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITLOW) |=> (state != ST_BUSY));
  // R9
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csLevel |-> !(strobes.commitPop || strobes.commitPush));
endmodule

// File: rtl/spi_fresh_slave.sv
module spi_fresh_slave
  import spis_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              cs,
  input  logic              sdi,
  output logic              sdo,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxEmpty,
  output logic              rxPop,
  output logic [DATA_W-1:0] txData,
  output logic              txPush,
  input  logic              txFull,
  input  logic [DATA_W-1:0] statusWord
);
  spisStrobes_t strobes;
  logic sclkRise, sclkFall, csLevel, sdiLevel;

  spis_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkRise(sclkRise),
    .sclkFall(sclkFall),
    .csLevel (csLevel),
    .sdiLevel(sdiLevel),
    .strobes (strobes)
  );

  spis_dpath #(.SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .sclk      (sclk),
    .cs        (cs),
    .sdi       (sdi),
    .rxData    (rxData),
    .rxEmpty   (rxEmpty),
    .txFull    (txFull),
    .statusWord(statusWord),
    .strobes   (strobes),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .csLevel   (csLevel),
    .sdiLevel  (sdiLevel),
    .sdo       (sdo),
    .rxPop     (rxPop),
    .txPush    (txPush),
    .txData    (txData)
  );
endmodule

// File: tb/sim_spi_fresh_slave.sv
module sim_spi_fresh_slave;
  localparam int TX_CAP = 2;
  localparam int NVEC = 8;
  // {dir, sel, writeByte, expByte, expFlag, expPop}
  localparam logic [19:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 8'h00, 8'hA5, 1'b0, 1'b1},  // R5 data read, fresh
    {1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b0},  // R7 status read
    {1'b1, 1'b0, 8'h00, 8'h3C, 1'b0, 1'b1},  // R5 second fresh byte
    {1'b1, 1'b0, 8'h00, 8'h3C, 1'b1, 1'b0},  // R6 empty, repeat
    {1'b0, 1'b0, 8'h81, 8'h00, 1'b0, 1'b0},  // R8 write accepted
    {1'b0, 1'b1, 8'h7E, 8'h00, 1'b0, 1'b0},  // R8 write accepted
    {1'b0, 1'b0, 8'h11, 8'h00, 1'b1, 1'b0},  // R8 sink full, dropped
    {1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b0}   // R3 status select
  };

  logic clk = 0, rstN = 0, sclk = 0, cs = 0, sdi = 0;
  logic sdo, rxPop, txPush;
  logic [7:0] txData;
  logic [7:0] rxMem [16];
  int rxHead = 0, rxTail = 0, popCnt = 0, txCnt = 0;
  logic [7:0] txMem [8];
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_fresh_slave u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .cs(cs), .sdi(sdi), .sdo(sdo),
    .rxData(rxMem[rxHead[3:0]]), .rxEmpty(rxHead == rxTail), .rxPop(rxPop),
    .txData(txData), .txPush(txPush), .txFull(txCnt >= TX_CAP),
    .statusWord(8'h5A)
  );

  always @(posedge clk) begin
    if (rxPop) begin
      rxHead <= rxHead + 1;
      popCnt <= popCnt + 1;
    end
    if (txPush) begin
      txMem[txCnt[2:0]] <= txData;
      txCnt <= txCnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input bit dir, input bit sel, input logic [7:0] wb,
                       input int nBits, input bit dropCs,
                       output logic [7:0] rb, output logic fl);
    rb = '0; fl = 0;
    cs = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      sdi = (i == 0) ? dir : (i == 1) ? sel : (i <= 9) ? wb[9-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i >= 2 && i <= 9) rb[9-i] = sdo;
      if (i == 10) fl = sdo;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    if (dropCs) begin
      cs = 0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic fl;
    int p0;
    rxMem[0] = 8'hA5; rxMem[1] = 8'h3C; rxTail = 2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sdo", sdo, 0);
    chk("R1 rxPop", rxPop, 0);
    chk("R1 txPush", txPush, 0);
    rstN = 1;
    repeat (6) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      p0 = popCnt;
      frame(VECS[v][19], VECS[v][18], VECS[v][17:10], 11, 1'b1, rb, fl);
      chk($sformatf("R4 vec%0d byte", v), rb, VECS[v][9:2]);
      chk($sformatf("R5/R6/R7/R8 vec%0d flag", v), fl, VECS[v][1]);
      chk($sformatf("R5 vec%0d pops", v), popCnt - p0, VECS[v][0]);
    end

    // R8 pushed bytes and drop on full
    chk("R8 push count", txCnt, 2);
    chk("R8 first pushed", txMem[0], 8'h81);
    chk("R8 second pushed", txMem[1], 8'h7E);

    // R9 aborted read: no pop
    rxMem[2] = 8'h99; rxTail = 3;
    frame(1'b1, 1'b0, 8'h00, 5, 1'b1, rb, fl);
    chk("R9 abort no pop", popCnt, 2);
    chk("R9 abort sdo idle", sdo, 0);

    // R9 next frame after abort is clean; keep cs high afterwards
    frame(1'b1, 1'b0, 8'h00, 11, 1'b0, rb, fl);
    chk("R9 read after abort byte", rb, 8'h99);
    chk("R9 read after abort flag", fl, 0);
    chk("R5 pop after abort", popCnt, 3);

    // R2 clocks with cs never low are ignored
    rxMem[3] = 8'h42; rxTail = 4;
    frame(1'b1, 1'b0, 8'h00, 11, 1'b1, rb, fl);
    chk("R2 held cs byte", rb, 8'h00);
    chk("R2 held cs flag", fl, 0);
    chk("R2 held cs no pop", popCnt, 3);

    // R2 after cs low, frame works again
    frame(1'b1, 1'b0, 8'h00, 11, 1'b1, rb, fl);
    chk("R2 rearmed byte", rb, 8'h42);
    chk("R2 rearmed pop", popCnt, 4);

    // R6 empty again: repeats 42 with stale flag
    frame(1'b1, 1'b0, 8'h00, 11, 1'b1, rb, fl);
    chk("R6 repeat byte", rb, 8'h42);
    chk("R6 stale flag", fl, 1);
    chk("R6 no pop", popCnt, 4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule